// File: doc/BRIEF.md
# Multi-Length AES Key Schedule Generator

This block takes an AES cipher key of 128, 192 or 256 bits and expands it into the full list of 32-bit round-key words. Its internal store holds that list, and any round key can be read from it as a 128-bit value. A start pulse loads the key words and the chosen length. The first Nk words are the key itself. The remaining words are then generated one per clock. When the schedule is complete, a done flag rises and stays high until the next accepted start. The three key lengths share one word datapath. A few multiplexers, steered by the length, decide when RotWord, SubWord and the round constant are applied. They also decide when the extra SubWord step used only by 256-bit keys is applied.

The controller has three states. `KS_IDLE` is the reset state. `KS_EXPAND` generates words. `KS_DONE` holds the finished schedule. There are three transitions. *accept-from-idle* moves KS_IDLE to KS_EXPAND on start. *last-word* moves KS_EXPAND to KS_DONE when the final word is written. *restart* moves KS_DONE to KS_EXPAND on start. In KS_EXPAND the start input has no effect.

Top module: `aes_keysched`

## Requirements
- R1: After reset, `done` and `busy` are both low.
- R2: `key_len` selects the key size: 2'b00 gives 128 bits (Nk=4, 44 words), 2'b01 gives 192 bits (Nk=6, 52 words), and 2'b10 or 2'b11 give 256 bits (Nk=8, 60 words). `busy` is high exactly while words are being generated.
- R3: Key word j sits at `key_in[255-32*j -: 32]` and becomes schedule word j, for j < Nk. Round 0 therefore reads back as the first four key words.
- R4: For a 128-bit key, word i (i ≥ 4) is w[i-4] XOR temp. Here temp is SubWord(RotWord(w[i-1])) XOR Rcon when i mod 4 = 0, and w[i-1] otherwise.
- R5: For a 192-bit key, the same rule holds with Nk=6. The RotWord/SubWord/Rcon step applies when i mod 6 = 0.
- R6: For a 256-bit key, the rule holds with Nk=8. In addition, temp is SubWord(w[i-1]) alone when i mod 8 = 4.
- R7: The round constant sits in the top byte of the word. It starts at 0x01 and is doubled in GF(2^8) modulo 0x11B after each use, so 0x80 is followed by 0x1B and then 0x36.
- R8: A start while `busy` is high is ignored. This includes a start in the cycle that writes the final word. The running schedule, its length and its timing are unchanged.
- R9: A start while `done` is high is accepted. `done` falls and `busy` rises on the next clock.
- R10: `done` rises exactly 3·Nk+28 clock edges after the edge that accepts start: 40, 46 or 52 edges.
- R11: `rd_key` combinationally returns {w[4r], w[4r+1], w[4r+2], w[4r+3]} for r = `rd_round`, with w[4r] in bits 127:96. Any round above Nk+6 reads as zero.
- R12: A start in the idle state is accepted. `busy` is high on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load the key and begin expansion |
| key_len | input | 2 | Key size select |
| key_in | input | 256 | Key words, word 0 in the top 32 bits |
| rd_round | input | 4 | Round index to read |
| rd_key | output | 128 | Selected round key |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | Schedule complete |

## Verification
Two functions can coincide: a new start request, and the write of the final schedule word that ends expansion. The bench raises start in exactly the cycle before the last-word edge. It also raises start once in the middle of a 256-bit run, each time with a different key and length. A correct block ignores both requests. The bench judges this three ways. `done` must still rise after exactly 52 edges. Every round key must match a reference schedule computed from the original key. A final round must equal a known published value.

// File: rtl/aes_ks_pkg.sv
`timescale 1ns/1ps
package aes_ks_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        KS_IDLE   = 2'd0,
        KS_EXPAND = 2'd1,
        KS_DONE   = 2'd2
    } ks_state_e;

    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

    // multiplicative inverse as a^254 (zero maps to zero)
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] p2, p3, p12, p15, p240, p252;
        p2   = gf_mul(a, a);
        p3   = gf_mul(p2, a);
        p12  = gf_mul(gf_mul(p3, p3), gf_mul(p3, p3));
        p15  = gf_mul(p12, p3);
        p240 = gf_mul(p15, p15);
        p240 = gf_mul(p240, p240);
        p240 = gf_mul(p240, p240);
        p240 = gf_mul(p240, p240);
        p252 = gf_mul(p240, p12);
        return gf_mul(p252, p2);
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [7:0] sbox_byte(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

endpackage

// File: rtl/ks_subword.sv
`timescale 1ns/1ps
module ks_subword
    import aes_ks_pkg::*;
#(
    parameter int BYTES = 4
) (
    input  logic [BYTES*8-1:0] word_in,
    output logic [BYTES*8-1:0] word_out
);

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign word_out[b*8 +: 8] = sbox_byte(word_in[b*8 +: 8]);
    end

endmodule

// File: rtl/ks_word_path.sv
`timescale 1ns/1ps
module ks_word_path
    import aes_ks_pkg::*;
(
    input  logic [WORD_W-1:0] prev_word,
    input  logic [WORD_W-1:0] back_word,
    input  logic              rot_step,
    input  logic              sub_only_step,
    input  logic [7:0]        rcon,
    output logic [WORD_W-1:0] new_word
);

    logic [WORD_W-1:0] rotated;
    logic [WORD_W-1:0] sbox_in;
    logic [WORD_W-1:0] sbox_out;
    logic [WORD_W-1:0] temp;

    assign rotated = {prev_word[WORD_W-9:0], prev_word[WORD_W-1 -: 8]};

    // one S-box bank is shared by the rotate step and the 256-bit extra step
    assign sbox_in = rot_step ? rotated : prev_word;

    ks_subword #(.BYTES(WORD_W/8)) u_sub (
        .word_in  (sbox_in),
        .word_out (sbox_out)
    );

    always_comb begin
        if (rot_step)
            temp = sbox_out ^ {rcon, {(WORD_W-8){1'b0}}};
        else if (sub_only_step)
            temp = sbox_out;
        else
            temp = prev_word;
    end

    assign new_word = back_word ^ temp;

endmodule

// File: rtl/ks_store.sv
`timescale 1ns/1ps
module ks_store
    import aes_ks_pkg::*;
#(
    parameter int DEPTH  = 60,
    parameter int LOAD_N = 8,
    parameter int AW     = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [LOAD_N*WORD_W-1:0] load_words,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [AW-1:0]            addr_a,
    input  logic [AW-1:0]            addr_b,
    output logic [WORD_W-1:0]        word_a,
    output logic [WORD_W-1:0]        word_b,
    input  logic [AW-1:0]            rk_base,
    output logic [4*WORD_W-1:0]      rk_words
);

    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        if (e < LOAD_N) begin : g_keyed
            always_ff @(posedge clk) begin
                if (load)
                    mem[e] <= load_words[(LOAD_N-1-e)*WORD_W +: WORD_W];
                else if (wr_en && wr_addr == AW'(e))
                    mem[e] <= wr_data;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (wr_en && wr_addr == AW'(e))
                    mem[e] <= wr_data;
            end
        end
    end

    assign word_a = (int'(addr_a) < DEPTH) ? mem[addr_a] : '0;
    assign word_b = (int'(addr_b) < DEPTH) ? mem[addr_b] : '0;

    for (genvar q = 0; q < 4; q++) begin : g_rk
        logic [AW-1:0] ra;
        assign ra = rk_base + AW'(q);
        assign rk_words[(3-q)*WORD_W +: WORD_W] = (int'(ra) < DEPTH) ? mem[ra] : '0;
    end

    AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (mem[0] == $past(load_words[LOAD_N*WORD_W-1 -: WORD_W]))) // R3
        else $error("key word 0 not stored");

endmodule

// File: rtl/aes_keysched.sv
`timescale 1ns/1ps
module aes_keysched
    import aes_ks_pkg::*;
#(
    parameter int MAX_NK = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               key_len,
    input  logic [MAX_NK*WORD_W-1:0] key_in,
    input  logic [3:0]               rd_round,
    output logic [4*WORD_W-1:0]      rd_key,
    output logic                     busy,
    output logic                     done
);

    localparam int MAX_WORDS = 4 * (MAX_NK + 7);
    localparam int AW        = $clog2(MAX_WORDS);

    ks_state_e state_q, state_d;

    logic [3:0]        nk_q, nk_sel;
    logic [AW-1:0]     idx_q;
    logic [2:0]        pos_q;
    logic [7:0]        rcon_q;
    logic [AW-1:0]     nw_cur;
    logic [3:0]        nr_cur;
    logic              accept;
    logic              last_word;
    logic              expanding;
    logic [WORD_W-1:0] word_a, word_b, new_word;
    logic [4*WORD_W-1:0] rk_words;
    logic              rd_ok;

    // key size decode: 00 -> 4 words, 01 -> 6 words, otherwise 8 words
    always_comb begin
        unique case (key_len)
            2'b00:   nk_sel = 4'd4;
            2'b01:   nk_sel = 4'd6;
            default: nk_sel = 4'd8;
        endcase
    end

    assign expanding = (state_q == KS_EXPAND);
    assign accept    = start && !expanding;
    assign nw_cur    = AW'({nk_q, 2'b00}) + AW'(28);
    assign last_word = (idx_q == nw_cur - AW'(1));
    assign nr_cur    = nk_q + 4'd6;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_IDLE:   if (start)     state_d = KS_EXPAND;
            KS_EXPAND: if (last_word) state_d = KS_DONE;
            KS_DONE:   if (start)     state_d = KS_EXPAND;
            default:                  state_d = KS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = (state_q == KS_EXPAND);
        done = (state_q == KS_DONE);
    end

    // word counters and round constant
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nk_q   <= 4'd4;
            idx_q  <= AW'(4);
            pos_q  <= 3'd0;
            rcon_q <= 8'h01;
        end else if (accept) begin
            nk_q   <= nk_sel;
            idx_q  <= AW'(nk_sel);
            pos_q  <= 3'd0;
            rcon_q <= 8'h01;
        end else if (expanding) begin
            idx_q <= idx_q + AW'(1);
            pos_q <= (pos_q == 3'(nk_q - 4'd1)) ? 3'd0 : pos_q + 3'd1;
            if (pos_q == 3'd0) rcon_q <= gf_dbl(rcon_q);
        end
    end

    ks_word_path u_path (
        .prev_word     (word_a),
        .back_word     (word_b),
        .rot_step      (pos_q == 3'd0),
        .sub_only_step (nk_q == 4'd8 && pos_q == 3'd4),
        .rcon          (rcon_q),
        .new_word      (new_word)
    );

    ks_store #(.DEPTH(MAX_WORDS), .LOAD_N(MAX_NK), .AW(AW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_words (key_in),
        .wr_en      (expanding),
        .wr_addr    (idx_q),
        .wr_data    (new_word),
        .addr_a     (idx_q - AW'(1)),
        .addr_b     (idx_q - AW'(nk_q)),
        .word_a     (word_a),
        .word_b     (word_b),
        .rk_base    (AW'({rd_round, 2'b00})),
        .rk_words   (rk_words)
    );

    assign rd_ok  = (rd_round <= nr_cur);
    assign rd_key = rd_ok ? rk_words : '0;

    // checker: edges spent generating since the last accepted start
    logic [7:0] chk_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         chk_cnt <= 8'd0;
        else if (accept)    chk_cnt <= 8'd0;
        else if (expanding) chk_cnt <= chk_cnt + 8'd1;
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (chk_cnt == 8'(nw_cur) - 8'(nk_q))) // R10
        else $error("done latency wrong");

    AST_IGNORE_START_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last_word) |=> (busy && idx_q == $past(idx_q) + AW'(1) && $stable(nk_q))) // R8
        else $error("start accepted mid expansion");

    AST_IGNORE_START_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && last_word) |=> (done && $stable(nk_q))) // R8
        else $error("start accepted on final word");

    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (busy && !done)) // R9
        else $error("restart from done failed");

    AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KS_IDLE && start) |=> busy) // R12
        else $error("start from idle lost");

    AST_RCON_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rcon_q != 8'h00)) // R7
        else $error("round constant collapsed");

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (4'(pos_q) < nk_q)) // R6
        else $error("word position out of range");

endmodule

// File: tb/aes_keysched_bench.sv
`timescale 1ns/1ps
module aes_keysched_bench;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   key_len = 2'b00;
    logic [255:0] key_in = '0;
    logic [3:0]   rd_round = 4'd0;
    logic [127:0] rd_key;
    logic         busy, done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aes_keysched u_aes_keysched (
        .clk(clk), .rst_n(rst_n), .start(start), .key_len(key_len),
        .key_in(key_in), .rd_round(rd_round), .rd_key(rd_key),
        .busy(busy), .done(done)
    );

    // reference model
    logic [7:0]  sb_tab [256];
    logic [31:0] ref_w  [60];

    function automatic logic [7:0] rl(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [7:0] xt(input logic [7:0] v);
        return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
    endfunction

    task automatic build_sbox();
        logic [7:0] p, q;
        p = 8'h01; q = 8'h01;
        do begin
            p = p ^ xt(p);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b00};
            q = q ^ {q[3:0], 4'h0};
            if (q[7]) q = q ^ 8'h09;
            sb_tab[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
        end while (p != 8'h01);
        sb_tab[0] = 8'h63;
    endtask

    function automatic logic [31:0] sub4(input logic [31:0] w);
        return {sb_tab[w[31:24]], sb_tab[w[23:16]], sb_tab[w[15:8]], sb_tab[w[7:0]]};
    endfunction

    task automatic ref_expand(input logic [255:0] k, input int nk);
        logic [7:0]  rc;
        logic [31:0] t;
        rc = 8'h01;
        for (int j = 0; j < nk; j++) ref_w[j] = k[255-32*j -: 32];
        for (int i = nk; i < 4*nk+28; i++) begin
            t = ref_w[i-1];
            if (i % nk == 0) begin
                t = sub4({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = xt(rc);
            end else if (nk == 8 && i % 8 == 4) begin
                t = sub4(t);
            end
            ref_w[i] = ref_w[i-nk] ^ t;
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard
    typedef struct {
        logic [127:0] val;
        int           rnd;
    } sb_item_t;
    sb_item_t exp_q[$];
    string    sb_req = "R4";
    bit       mon_en = 1'b0;

    initial begin : monitor
        sb_item_t it;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (mon_en) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, {sb_req, " scoreboard empty"}, rd_key, '0);
                end else begin
                    it = exp_q.pop_front();
                    check(rd_key == it.val && int'(rd_round) == it.rnd, sb_req, rd_key, it.val);
                end
            end
        end
    end

    task automatic run_key(input logic [255:0] k, input logic [1:0] len, input int nk,
                           input bit ign_mid, input bit ign_last, input string req);
        int cnt;
        int exp_cnt;
        exp_cnt = 3*nk + 28;
        @(negedge clk);
        key_in = k; key_len = len; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && done == 1'b0, "R12/R9 busy after accept", {126'd0, busy, done}, 128'd2);
        cnt = 0;
        while (cnt < 200) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            start = 1'b0;
            if (done) break;
            if (ign_mid && cnt == 10) begin
                start = 1'b1; key_in = ~k; key_len = 2'b00;
            end
            if (ign_last && cnt == exp_cnt - 1) begin
                start = 1'b1; key_in = {k[127:0], k[255:128]}; key_len = 2'b01;
            end
        end
        check(cnt == exp_cnt, "R10 done latency", 128'(cnt), 128'(exp_cnt));
        check(busy == 1'b0, "R2 busy low at done", {127'd0, busy}, 128'd0);
        ref_expand(k, nk);
        sb_req = req;
        for (int r = 0; r <= nk + 6; r++) begin
            sb_item_t it;
            it.val = {ref_w[4*r], ref_w[4*r+1], ref_w[4*r+2], ref_w[4*r+3]};
            it.rnd = r;
            exp_q.push_back(it);
        end
        for (int r = 0; r <= nk + 6; r++) begin
            @(negedge clk);
            rd_round = 4'(r);
            mon_en = 1'b1;
        end
        @(negedge clk);
        mon_en = 1'b0;
        check(exp_q.size() == 0, {req, " scoreboard drained"}, 128'(exp_q.size()), 128'd0);
    endtask

    task automatic read_round(input int r, input logic [127:0] exp, input string req);
        @(negedge clk);
        rd_round = 4'(r);
        #(CLK_PERIOD/4);
        check(rd_key == exp, req, rd_key, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R10 watchdog expired actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        logic [255:0] k128a, k128b, k192, k256;
        build_sbox();
        k128a = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'hdeadbeef_cafef00d_01234567_89abcdef};
        k128b = {128'h000102030405060708090a0b0c0d0e0f, 128'hffffffff_00000000_ffffffff_00000000};
        k192  = {192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'h5a5a5a5a_a5a5a5a5};
        k256  = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        check(done == 1'b0 && busy == 1'b0, "R1 reset state", {126'd0, busy, done}, 128'd0);

        // 128-bit from idle
        run_key(k128a, 2'b00, 4, 1'b0, 1'b0, "R4 128-bit schedule");
        read_round(0, k128a[255:128], "R3 round 0 is key");
        read_round(10, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R7 128-bit final round");
        for (int r = 11; r < 16; r++) read_round(r, '0, "R11 out-of-range round");

        // restart from done
        run_key(k128b, 2'b00, 4, 1'b0, 1'b0, "R9 restart schedule");
        read_round(10, 128'h13111d7fe3944a17f307a78b4d2b30c5, "R4 128-bit vector");

        // 192-bit
        run_key(k192, 2'b01, 6, 1'b0, 1'b0, "R5 192-bit schedule");
        read_round(12, 128'ha4970a331a78dc09c418c271e3a41d5d, "R5 192-bit vector");
        read_round(13, '0, "R11 192-bit beyond last");
        read_round(0, k192[255:128], "R3 192-bit round 0");

        // 256-bit with two ignored starts
        run_key(k256, 2'b10, 8, 1'b1, 1'b1, "R8 256-bit with ignored starts");
        read_round(14, 128'h24fc79ccbf0979e9371ac23c6d68de36, "R6 256-bit vector");
        read_round(15, '0, "R11 256-bit beyond last");
        read_round(1, k256[127:0], "R3 256-bit upper key half");

        // encoding 11 behaves as 256
        run_key(k256, 2'b11, 8, 1'b0, 1'b0, "R2 key_len 11 schedule");
        read_round(14, 128'h24fc79ccbf0979e9371ac23c6d68de36, "R2 key_len 11 vector");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule